// File: doc/BRIEF.md
# Quad-Channel Serial DAC Command Receiver

This block is the digital front end of a four-channel, 8-bit converter. A host drives three serial lines: a shift clock, a data line and a load strobe. A fourth line, the update strobe, is optional. The block brings every line into the system clock domain and finds its falling edges there. It then collects fixed-length command words. Each word carries a channel address, a gain flag and an 8-bit code. A load strobe writes the word into the addressed channel's input register. An update strobe copies all input registers to the output registers, which drive the converter.

When the update strobe is held low, an output follows its input register in the same cycle as the load. When the strobe is held high, several channels can be staged and then switched together. A load that arrives part way through a word, or with no complete word waiting, is rejected. The rejection is signalled with a one-cycle error pulse.

Top module: `dac_cmd_rx`

## Requirements
- R1: After reset, every output code and every gain bit is zero. Neither the frame-complete pulse nor the error pulse is asserted.
- R2: Data is sampled on each falling edge of the synchronised shift clock, most significant bit first. In the 11-bit word, bits 10:9 are the channel address (00 = channel 0 through 11 = channel 3), bit 8 is the gain flag (1 = gain x2, 0 = gain x1), and bits 7:0 are the unsigned code. Channel i appears on `code_o[8*i+7:8*i]` and `gain_o[i]`.
- R3: `frame_done_o` pulses high for exactly one cycle after every 11th sampled bit, and the bit count then restarts at zero. Of words sent back to back, the last complete one is the word a later load uses.
- R4: A falling load edge, with a complete word waiting and no bits collected since, writes that word into the addressed channel's input register only. The waiting word is consumed.
- R5: While the update strobe is high, a load leaves all outputs unchanged. A falling edge of the update strobe copies all four input registers to the outputs at once.
- R6: While the update strobe is low, the addressed channel's output takes the new code and gain in the same cycle as its input register.
- R7: A falling load edge that finds a partial word, or no waiting word, changes no register. It clears the bit count and discards any waiting word, and it pulses `frame_err_o` for one cycle. A later complete word is accepted normally.
- R8: Outputs change only on an accepted load or on a falling update strobe. Shifting bits alone leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk_i | input | 1 | Serial shift clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| load_i | input | 1 | Load strobe, active falling edge |
| ldac_i | input | 1 | Update strobe, active falling edge; tie low for immediate update |
| code_o | output | 32 | Four 8-bit output codes, channel 0 in the low byte |
| gain_o | output | 4 | Gain bit per channel, 1 = x2 |
| frame_done_o | output | 1 | One-cycle pulse per complete 11-bit word |
| frame_err_o | output | 1 | One-cycle pulse per rejected load |

## Verification
The bench builds the block with its defaults: four channels, 8-bit codes and two synchroniser stages, which gives an 11-bit word. With these values all four address codes, both gain settings and codes across the full 8-bit range can be reached. Rejected loads can be tested after every partial length from 1 to 10 bits. The bench switches the update strobe between staged and immediate modes in the middle of random traffic, so both output paths and the transfer of all channels at once are exercised.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;

    // serial pin order inside the synchroniser bundle
    localparam int PIN_N  = 4;
    localparam int P_SCLK = 0;
    localparam int P_SDAT = 1;
    localparam int P_LOAD = 2;
    localparam int P_LDAC = 3;

    // events seen after synchronisation
    typedef struct packed {
        logic sclk_fall;
        logic load_fall;
        logic ldac_fall;
        logic sdat;
        logic ldac_lvl;
    } pin_ev_t;

endpackage

// File: rtl/dac_rx_pinsync.sv
module dac_rx_pinsync
    import dac_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_N-1:0] pins_i,
    output pin_ev_t          ev_o
);

    typedef struct packed {
        logic [STAGES-1:0][PIN_N-1:0] chain;
        logic [PIN_N-1:0]             prev;
    } sync_st_t;

    sync_st_t s_d, s_q;
    logic [PIN_N-1:0] cur;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = pins_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur = s_q.chain[STAGES-1];

    always_comb begin
        ev_o.sclk_fall = s_q.prev[P_SCLK] & ~cur[P_SCLK];
        ev_o.load_fall = s_q.prev[P_LOAD] & ~cur[P_LOAD];
        ev_o.ldac_fall = s_q.prev[P_LDAC] & ~cur[P_LDAC];
        ev_o.sdat      = cur[P_SDAT];
        ev_o.ldac_lvl  = cur[P_LDAC];
    end

endmodule

// File: rtl/dac_rx_framer.sv
module dac_rx_framer #(
    parameter  int FRAME_W = 11,
    localparam int CNT_W   = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_fall_i,
    input  logic               load_fall_i,
    input  logic               sdat_i,
    output logic               lat_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               done_o,
    output logic               err_o,
    output logic [CNT_W-1:0]   cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shreg;
        logic [FRAME_W-1:0] held;
        logic               vld;
        logic               done;
        logic               err;
    } frm_st_t;

    frm_st_t s_d, s_q;
    logic [FRAME_W-1:0] shifted;
    logic accept;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        shifted  = {s_q.shreg[FRAME_W-2:0], sdat_i};
        accept   = load_fall_i && s_q.vld && (s_q.cnt == '0);
        if (load_fall_i) begin
            // a load always closes the current word, good or bad
            s_d.cnt = '0;
            s_d.vld = 1'b0;
            s_d.err = !accept;
        end else if (sclk_fall_i) begin
            s_d.shreg = shifted;
            if (s_q.cnt == CNT_W'(FRAME_W - 1)) begin
                s_d.cnt  = '0;
                s_d.held = shifted;
                s_d.vld  = 1'b1;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lat_o   = accept;
    assign frame_o = s_q.held;
    assign done_o  = s_q.done;
    assign err_o   = s_q.err;
    assign cnt_o   = s_q.cnt;

endmodule

// File: rtl/dac_rx_bank.sv
module dac_rx_bank #(
    parameter  int NCH    = 4,
    parameter  int CODE_W = 8,
    localparam int ADDR_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lat_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  gain_i,
    input  logic [CODE_W-1:0]     code_i,
    input  logic                  upd_i,
    input  logic                  ldac_lvl_i,
    output logic [NCH*CODE_W-1:0] code_o,
    output logic [NCH-1:0]        gain_o
);

    typedef struct packed {
        logic [NCH-1:0][CODE_W-1:0] in_code;
        logic [NCH-1:0][CODE_W-1:0] out_code;
        logic [NCH-1:0]             in_gain;
        logic [NCH-1:0]             out_gain;
    } bank_st_t;

    bank_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NCH; i++) begin
            if (lat_i && (addr_i == ADDR_W'(i))) begin
                s_d.in_code[i] = code_i;
                s_d.in_gain[i] = gain_i;
            end
        end
        for (int i = 0; i < NCH; i++) begin
            // update strobe low makes the output path transparent
            if (upd_i || (lat_i && !ldac_lvl_i && (addr_i == ADDR_W'(i)))) begin
                s_d.out_code[i] = s_d.in_code[i];
                s_d.out_gain[i] = s_d.in_gain[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign code_o[g*CODE_W +: CODE_W] = s_q.out_code[g];
        assign gain_o[g]                  = s_q.out_gain[g];
    end

endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
    import dac_rx_pkg::*;
#(
    parameter  int NCH         = 4,
    parameter  int CODE_W      = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int ADDR_W      = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int FRAME_W     = ADDR_W + 1 + CODE_W,
    localparam int CNT_W       = $clog2(FRAME_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_i,
    input  logic                  sdata_i,
    input  logic                  load_i,
    input  logic                  ldac_i,
    output logic [NCH*CODE_W-1:0] code_o,
    output logic [NCH-1:0]        gain_o,
    output logic                  frame_done_o,
    output logic                  frame_err_o
);

    pin_ev_t            ev;
    logic [PIN_N-1:0]   pins;
    logic               lat_evt;
    logic               upd_evt;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   bit_cnt;

    always_comb begin
        pins         = '0;
        pins[P_SCLK] = sclk_i;
        pins[P_SDAT] = sdata_i;
        pins[P_LOAD] = load_i;
        pins[P_LDAC] = ldac_i;
    end

    dac_rx_pinsync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins),
        .ev_o   (ev)
    );

    dac_rx_framer #(.FRAME_W(FRAME_W)) i_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_fall_i (ev.sclk_fall),
        .load_fall_i (ev.load_fall),
        .sdat_i      (ev.sdat),
        .lat_o       (lat_evt),
        .frame_o     (frame),
        .done_o      (frame_done_o),
        .err_o       (frame_err_o),
        .cnt_o       (bit_cnt)
    );

    assign upd_evt = ev.ldac_fall;

    dac_rx_bank #(.NCH(NCH), .CODE_W(CODE_W)) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .lat_i      (lat_evt),
        .addr_i     (frame[FRAME_W-1 -: ADDR_W]),
        .gain_i     (frame[CODE_W]),
        .code_i     (frame[CODE_W-1:0]),
        .upd_i      (upd_evt),
        .ldac_lvl_i (ev.ldac_lvl),
        .code_o     (code_o),
        .gain_o     (gain_o)
    );

endmodule

// File: rtl/dac_cmd_rx_chk.sv
module dac_cmd_rx_chk #(
    parameter int NCH     = 4,
    parameter int CODE_W  = 8,
    parameter int FRAME_W = 11,
    parameter int CNT_W   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCH*CODE_W-1:0] code_o,
    input logic [NCH-1:0]        gain_o,
    input logic                  frame_done_o,
    input logic                  frame_err_o,
    input logic                  lat_evt,
    input logic                  upd_evt,
    input logic [CNT_W-1:0]      bit_cnt
);

    // R8
    outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_evt && !upd_evt) |=> ($stable(code_o) && $stable(gain_o)));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < CNT_W'(FRAME_W));

    // R7
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o);

    // R7
    err_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> (bit_cnt == '0));

    // R7
    err_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> !(frame_done_o));

endmodule

bind dac_cmd_rx dac_cmd_rx_chk #(
    .NCH(NCH), .CODE_W(CODE_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .code_o       (code_o),
    .gain_o       (gain_o),
    .frame_done_o (frame_done_o),
    .frame_err_o  (frame_err_o),
    .lat_evt      (lat_evt),
    .upd_evt      (upd_evt),
    .bit_cnt      (bit_cnt)
);

// File: tb/test_dac_cmd_rx.sv
`timescale 1ns/1ps
module test_dac_cmd_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1, sdata = 1'b0, load = 1'b1, ldac = 1'b1;
    logic [31:0] code_o;
    logic [3:0]  gain_o;
    logic        frame_done_o, frame_err_o;

    int n_cmp = 0, n_bad = 0;
    int done_seen = 0, err_seen = 0;
    int m_done = 0, m_err = 0;
    bit finished = 1'b0;

    // bench model
    logic [7:0]  m_in_code [4];
    logic [7:0]  m_out_code[4];
    logic        m_in_gain [4];
    logic        m_out_gain[4];
    logic [10:0] m_sh = '0, m_frame = '0;
    int          m_cnt = 0;
    bit          m_pend = 1'b0;
    bit          ldac_low = 1'b0;

    always #2 clk = ~clk;

    dac_cmd_rx i_dac_cmd_rx (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata),
        .load_i(load), .ldac_i(ldac), .code_o(code_o), .gain_o(gain_o),
        .frame_done_o(frame_done_o), .frame_err_o(frame_err_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_done_o) done_seen++;
            if (frame_err_o)  err_seen++;
        end
    end

    function automatic logic [10:0] mk_word(input int ch, input logic g, input logic [7:0] c);
        return {ch[1:0], g, c};
    endfunction

    function automatic logic [31:0] exp_codes();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) v[i*8 +: 8] = m_out_code[i];
        return v;
    endfunction

    function automatic logic [3:0] exp_gains();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = m_out_gain[i];
        return v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string rid, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rid, what, act, exp);
        end
    endtask

    task automatic check_outs(input string rid);
        chk(code_o === exp_codes(), rid, "codes", code_o, exp_codes());
        chk(gain_o === exp_gains(), rid, "gains", {28'd0, gain_o}, {28'd0, exp_gains()});
    endtask

    task automatic check_pulses(input string rid);
        chk(done_seen == m_done, rid, "done pulses", done_seen, m_done);
        chk(err_seen == m_err, rid, "error pulses", err_seen, m_err);
    endtask

    task automatic send_bit(input logic b);
        sdata = b;
        tick(3);
        sclk = 1'b0;
        tick(4);
        sclk = 1'b1;
        tick(3);
        m_sh = {m_sh[9:0], b};
        if (m_cnt == 10) begin
            m_cnt = 0; m_pend = 1'b1; m_frame = m_sh; m_done++;
        end else begin
            m_cnt++;
        end
    endtask

    // sends the top n bits of w, MSB first
    task automatic send_bits(input logic [10:0] w, input int n);
        for (int k = 10; k > 10 - n; k--) send_bit(w[k]);
    endtask

    task automatic do_load();
        load = 1'b0;
        tick(4);
        load = 1'b1;
        tick(4);
        if (m_pend && m_cnt == 0) begin
            int ch = int'(m_frame[10:9]);
            m_in_code[ch] = m_frame[7:0];
            m_in_gain[ch] = m_frame[8];
            if (ldac_low) begin
                m_out_code[ch] = m_in_code[ch];
                m_out_gain[ch] = m_in_gain[ch];
            end
        end else begin
            m_err++;
        end
        m_cnt = 0;
        m_pend = 1'b0;
    endtask

    task automatic xfer_all();
        for (int i = 0; i < 4; i++) begin
            m_out_code[i] = m_in_code[i];
            m_out_gain[i] = m_in_gain[i];
        end
    endtask

    task automatic do_ldac_pulse();
        ldac = 1'b0;
        tick(4);
        ldac = 1'b1;
        tick(4);
        xfer_all();
    endtask

    task automatic set_ldac_low(input bit lo);
        if (lo && !ldac_low) begin
            ldac = 1'b0;
            xfer_all();
        end else if (!lo && ldac_low) begin
            ldac = 1'b1;
        end
        ldac_low = lo;
        tick(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 4; i++) begin
            m_in_code[i] = '0; m_out_code[i] = '0;
            m_in_gain[i] = 1'b0; m_out_gain[i] = 1'b0;
        end
        tick(5);
        // R1 reset state
        check_outs("R1");
        chk(frame_done_o == 1'b0 && frame_err_o == 1'b0, "R1", "pulses in reset",
            {30'd0, frame_done_o, frame_err_o}, 32'd0);
        rst_n = 1'b1;
        tick(5);
        check_outs("R1");

        // R2 R3 R5: staged word, outputs wait for update strobe
        send_bits(mk_word(2, 1'b1, 8'hA5), 11);
        check_pulses("R3");
        check_outs("R8");
        do_load();
        check_outs("R5");
        do_ldac_pulse();
        check_outs("R2");

        // R4: each channel gets its own word, then one update
        for (int c = 0; c < 4; c++) begin
            send_bits(mk_word(c, c[0], 8'(8'h11 * (c + 3))), 11);
            do_load();
            check_outs("R5");
        end
        do_ldac_pulse();
        check_outs("R4");
        check_pulses("R4");

        // R6: immediate update path
        set_ldac_low(1'b1);
        check_outs("R5");
        send_bits(mk_word(1, 1'b0, 8'h3C), 11);
        do_load();
        check_outs("R6");
        send_bits(mk_word(3, 1'b1, 8'hFF), 11);
        do_load();
        check_outs("R6");

        // R7: partial word then load is rejected, next word is fine
        send_bits(mk_word(0, 1'b1, 8'h81), 5);
        do_load();
        check_outs("R7");
        check_pulses("R7");
        send_bits(mk_word(0, 1'b1, 8'h81), 11);
        do_load();
        check_outs("R7");
        // R7: load with nothing waiting
        do_load();
        check_outs("R7");
        check_pulses("R7");

        // R3: two words back to back, second one counts
        send_bits(mk_word(2, 1'b0, 8'h00), 11);
        send_bits(mk_word(1, 1'b1, 8'h5A), 11);
        check_pulses("R3");
        do_load();
        check_outs("R3");

        // R7: complete word followed by a partial one is discarded
        send_bits(mk_word(2, 1'b1, 8'h77), 11);
        send_bits(mk_word(3, 1'b0, 8'h12), 3);
        do_load();
        check_outs("R7");
        check_pulses("R7");

        // random traffic
        for (int it = 0; it < 60; it++) begin
            int op = int'($urandom_range(0, 9));
            if (op <= 5) begin
                send_bits(mk_word(int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                                  8'($urandom_range(0, 255))), 11);
                check_outs("R8");
                do_load();
                check_outs(ldac_low ? "R6" : "R5");
            end else if (op == 6) begin
                send_bits(11'($urandom_range(0, 2047)), int'($urandom_range(1, 10)));
                do_load();
                check_outs("R7");
            end else if (op == 7) begin
                set_ldac_low(!ldac_low);
                check_outs("R5");
            end else if (op == 8) begin
                if (!ldac_low) do_ldac_pulse();
                check_outs("R5");
            end else begin
                do_load();
                check_outs("R7");
            end
            check_pulses("R3");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule